// File: doc/BRIEF.md
# Framebuffer line burst scheduler

The block produces the external-memory read requests that fetch one video line of framebuffer data for each line period. A line is fetched as a programmable number of equal-length bursts followed by one final burst whose length may differ. For a 1920-pixel line held at 8 pixels per 32-bit word (240 words) and a burst size B, software programs floor(239 / B) normal bursts of length B and one final burst that covers the remaining words.

Two registers configure the block. The configuration word holds an enable, the normal-burst count, both burst lengths and the increment applied after the final burst. The base register holds the framebuffer start word address. A frame-start strobe reloads the fetch pointer from the base register. A line-start strobe launches the burst sequence for one line. Each request carries an address and a length and is held on the output until the memory side takes it with ready. A line-start strobe that arrives while a line is still being fetched is remembered and raises a one-cycle underrun flag.

Top module: `line_burst_sched`

## Requirements
- R1: After reset no request is offered (req_valid = 0) and underrun is 0.
- R2: A write to offset 0 loads the configuration word: bit 31 enable, bits 30:24 normal-burst count, bits 23:16 normal length minus one, bits 15:8 final length minus one, bits 7:0 final increment. A write to offset 1 loads the base word address. Writes to any other offset change nothing.
- R3: A line issues `count` normal bursts at consecutive addresses spaced by the normal length, then one final burst. req_len_m1 carries the burst length minus one.
- R4: After the final burst is accepted the pointer advances by the final increment plus one, and the next line starts there.
- R5: While req_valid is 1 and req_ready is 0, req_valid, req_addr and req_len_m1 stay unchanged in the next cycle.
- R6: A frame-start strobe while no line is being fetched sets the pointer to the base register. If a line-start strobe arrives in the same cycle, that line starts at the base address.
- R7: A frame-start strobe during a line is held until the final burst of that line is accepted, then reloads the pointer and discards remembered line strobes.
- R8: A line-start strobe during a line (other than in the cycle the final burst is accepted) pulses underrun for one cycle and is remembered, so the next line starts in the cycle after the final burst is accepted.
- R9: While the enable is 0, line-start strobes start nothing and remembered strobes are dropped. A line already in progress still completes.
- R10: The line shape (count, both lengths, increment) is captured when a line starts; configuration writes during the line do not affect it.
- R11: A normal-burst count of 0 issues only the final burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register offset (0 configuration, 1 base) |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start strobe, reloads the pointer |
| line_start | input | 1 | Line-start strobe, launches one line fetch |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted when high with req_valid |
| req_addr | output | ADDR_W | Burst start word address |
| req_len_m1 | output | 8 | Burst length minus one |
| underrun | output | 1 | One-cycle pulse: line strobe arrived during a fetch |

## Verification
The functions that can coincide are the frame reload of the pointer and the launch of a line. Both strobes are raised in the same idle cycle, and the first request must carry the newly written base address. A frame strobe is also raised together with a line strobe in the middle of a line. There the bench judges that the running line keeps its addresses, that nothing follows its final burst, and that the next line begins at the new base. A separate case keeps a pending line strobe alive across the final acceptance, and the follow-on line must start in the very next cycle at the incremented pointer.

// File: rtl/fbls_pkg.sv
package fbls_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 7;
  localparam int LEN_W  = 8;
  localparam int STEP_W = LEN_W + 1;

  // Field order mirrors the bit positions of the configuration word.
  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] nlen_m1;
    logic [LEN_W-1:0] llen_m1;
    logic [LEN_W-1:0] linc;
  } cfg_t;

  // Per-line snapshot of the burst shape.
  typedef struct packed {
    logic [LEN_W-1:0] nlen_m1;
    logic [LEN_W-1:0] llen_m1;
    logic [LEN_W-1:0] linc;
  } shape_t;
endpackage

// File: rtl/fbls_regs.sv
module fbls_regs
  import fbls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] base
);
  localparam logic [CFG_AW-1:0] OFS_CFG  = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] OFS_BASE = CFG_AW'(1);

  cfg_t              cfg_q, cfg_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              cfg_ld, base_ld;

  always_comb begin
    cfg_ld  = wr_en && (wr_addr == OFS_CFG);
    base_ld = wr_en && (wr_addr == OFS_BASE);
    cfg_d   = cfg_t'(wr_data);
    base_d  = ADDR_W'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else begin
      if (cfg_ld)  cfg_q  <= cfg_d;
      if (base_ld) base_q <= base_d;
    end
  end

  assign cfg  = cfg_q;
  assign base = base_q;
endmodule

// File: rtl/fbls_pend.sv
module fbls_pend #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic pend_nz,
  output logic underrun
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] cnt_q, cnt_d;
  logic              urun_q, urun_d;
  logic              cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !dec) begin
      if (cnt_q != PEND_MAX) cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
    cnt_en = clr | inc | dec;
    urun_d = inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      urun_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      urun_q <= urun_d;
    end
  end

  assign pend_nz  = (cnt_q != '0);
  assign underrun = urun_q;
endmodule

// File: rtl/fbls_seq.sv
module fbls_seq
  import fbls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] base,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              pend_nz,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len_m1,
  output logic              pend_inc,
  output logic              pend_dec,
  output logic              pend_clr
);
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  shape_t            shape_q, shape_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              fpend_q, fpend_d;

  logic              acc, last, fin, free, frame_now, start;
  logic [STEP_W-1:0] step;
  logic              rem_en, cur_en, shape_en;

  always_comb begin
    acc       = busy_q & req_ready;
    last      = (rem_q == '0);
    fin       = acc & last;
    free      = ~busy_q | fin;
    frame_now = (frame_start | fpend_q) & free;
    start     = cfg.en & free & (line_start | (pend_nz & ~frame_now));

    step = last ? ({1'b0, shape_q.linc} + STEP_W'(1))
                : ({1'b0, shape_q.nlen_m1} + STEP_W'(1));

    if (frame_now)  cur_d = base;
    else if (acc)   cur_d = cur_q + ADDR_W'(step);
    else            cur_d = cur_q;
    cur_en = frame_now | acc;

    if (start)      busy_d = 1'b1;
    else if (fin)   busy_d = 1'b0;
    else            busy_d = busy_q;

    if (start)            rem_d = cfg.cnt;
    else if (acc && !last) rem_d = rem_q - 1'b1;
    else                  rem_d = rem_q;
    rem_en = start | acc;

    shape_d.nlen_m1 = cfg.nlen_m1;
    shape_d.llen_m1 = cfg.llen_m1;
    shape_d.linc    = cfg.linc;
    shape_en        = start;

    fpend_d  = (fpend_q | frame_start) & ~frame_now;

    pend_inc = line_start & cfg.en & ~free;
    pend_dec = start & ~line_start;
    pend_clr = frame_now | ~cfg.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rem_q   <= '0;
      shape_q <= '0;
      cur_q   <= '0;
      fpend_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      fpend_q <= fpend_d;
      if (rem_en)   rem_q   <= rem_d;
      if (cur_en)   cur_q   <= cur_d;
      if (shape_en) shape_q <= shape_d;
    end
  end

  assign req_valid  = busy_q;
  assign req_addr   = cur_q;
  assign req_len_m1 = last ? shape_q.llen_m1 : shape_q.nlen_m1;
endmodule

// File: rtl/line_burst_sched.sv
module line_burst_sched
  import fbls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 2,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len_m1,
  output logic              underrun
);
  cfg_t              cfg;
  logic [ADDR_W-1:0] base;
  logic              cfg_en;
  logic              pend_nz, pend_inc, pend_dec, pend_clr;

  assign cfg_en = cfg.en;

  fbls_regs #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .cfg     (cfg),
    .base    (base)
  );

  fbls_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .base        (base),
    .line_start  (line_start),
    .frame_start (frame_start),
    .pend_nz     (pend_nz),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len_m1  (req_len_m1),
    .pend_inc    (pend_inc),
    .pend_dec    (pend_dec),
    .pend_clr    (pend_clr)
  );

  fbls_pend #(.PEND_W(PEND_W)) i_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (pend_inc),
    .dec      (pend_dec),
    .clr      (pend_clr),
    .pend_nz  (pend_nz),
    .underrun (underrun)
  );
endmodule

// File: rtl/line_burst_sched_chk.sv
module line_burst_sched_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [ADDR_W-1:0] base,
  input logic              frame_start,
  input logic              line_start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_len_m1,
  input logic              underrun
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_len_m1)));

  assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(line_start) && $past(req_valid)));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !req_valid) |=> !req_valid);

  assert_same_cycle_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start && !req_valid && en) |=>
      (req_valid && (req_addr == $past(base))));

  assert_start_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(en));
endmodule

bind line_burst_sched line_burst_sched_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (cfg_en),
  .base        (base),
  .frame_start (frame_start),
  .line_start  (line_start),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_len_m1  (req_len_m1),
  .underrun    (underrun)
);

// File: tb/test_line_burst_sched.sv
module test_line_burst_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frame_start, line_start, req_ready;
  logic        req_valid, underrun;
  logic [31:0] req_addr;
  logic [7:0]  req_len_m1;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] ptr;

  always #4 clk = ~clk;

  line_burst_sched i_line_burst_sched (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .line_start(line_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .underrun(underrun)
  );

  function automatic logic [31:0] mk(input logic en, input logic [6:0] cnt,
      input logic [7:0] nl, input logic [7:0] ll, input logic [7:0] inc);
    return {en, cnt, nl, ll, inc};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input logic fr, input logic ln);
    frame_start = fr; line_start = ln;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0;
  endtask

  task automatic expect_burst(input logic [31:0] ea, input logic [7:0] el,
                              input int stall, input string tag);
    logic [31:0] a0;
    int w = 0;
    while (!req_valid && w < 50) begin @(negedge clk); w++; end
    chk(req_valid, {tag, " valid"}, 32'(req_valid), 1);
    chk(req_addr == ea, {tag, " addr"}, req_addr, ea);
    chk(req_len_m1 == el, {tag, " len"}, 32'(req_len_m1), 32'(el));
    a0 = req_addr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(req_valid && req_addr == a0, "R5 hold", req_addr, a0);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic run_line(input int cnt, input logic [7:0] nl, input logic [7:0] ll,
                          input logic [7:0] inc, input int stall, input string tag);
    for (int i = 0; i < cnt; i++) begin
      expect_burst(ptr, nl, stall, {tag, " normal R3"});
      ptr = ptr + 32'(nl) + 1;
    end
    expect_burst(ptr, ll, stall, {tag, " final R3"});
    ptr = ptr + 32'(inc) + 1;
  endtask

  task automatic expect_idle(input int cyc, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      seen |= req_valid;
      @(negedge clk);
    end
    seen |= req_valid;
    chk(!seen, tag, 32'(seen), 0);
  endtask

  task automatic t_reset();
    chk(req_valid == 1'b0, "R1 reset valid", 32'(req_valid), 0);
    chk(underrun == 1'b0, "R1 reset underrun", 32'(underrun), 0);
  endtask

  task automatic t_basic();
    wr(2'd1, 32'h1000);
    wr(2'd0, mk(1'b1, 7'd3, 8'd63, 8'd47, 8'd47));
    pulse(1'b1, 1'b0);
    ptr = 32'h1000;
    pulse(1'b0, 1'b1);
    run_line(3, 8'd63, 8'd47, 8'd47, 0, "R2 basic");
    expect_idle(3, "R3 idle after line");
    pulse(1'b0, 1'b1);
    chk(req_addr == 32'h10F0, "R4 next line start", req_addr, 32'h10F0);
    run_line(3, 8'd63, 8'd47, 8'd47, 2, "R5 stalled");
  endtask

  task automatic t_zero_count();
    wr(2'd0, mk(1'b1, 7'd0, 8'd7, 8'd15, 8'd31));
    pulse(1'b0, 1'b1);
    run_line(0, 8'd7, 8'd15, 8'd31, 1, "R11 only final");
    expect_idle(2, "R11 single burst");
    pulse(1'b0, 1'b1);
    run_line(0, 8'd7, 8'd15, 8'd31, 0, "R4 inc+1");
  endtask

  task automatic t_underrun();
    wr(2'd1, 32'h2000);
    wr(2'd0, mk(1'b1, 7'd1, 8'd3, 8'd3, 8'd3));
    pulse(1'b1, 1'b0);
    ptr = 32'h2000;
    pulse(1'b0, 1'b1);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    chk(underrun == 1'b1, "R8 underrun pulse", 32'(underrun), 1);
    @(negedge clk);
    chk(underrun == 1'b0, "R8 underrun one cycle", 32'(underrun), 0);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R8 first line");
    chk(req_valid && req_addr == 32'h2008, "R8 pending line immediate",
        req_addr, 32'h2008);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R8 second line");
    expect_idle(3, "R8 no extra line");
  endtask

  task automatic t_frame_defer();
    wr(2'd1, 32'h3000);
    pulse(1'b0, 1'b1);
    chk(req_addr == ptr, "R6 base write alone no reload", req_addr, ptr);
    pulse(1'b1, 1'b1);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R7 running line kept");
    expect_idle(3, "R7 pending dropped");
    ptr = 32'h3000;
    pulse(1'b0, 1'b1);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R7 new base");
  endtask

  task automatic t_same_cycle();
    wr(2'd1, 32'h4000);
    pulse(1'b1, 1'b1);
    ptr = 32'h4000;
    chk(req_valid && req_addr == 32'h4000, "R6 same cycle base", req_addr, 32'h4000);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R6 line");
    pulse(1'b1, 1'b0);
    ptr = 32'h4000;
    pulse(1'b0, 1'b1);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R6 idle reload");
  endtask

  task automatic t_snapshot();
    wr(2'd1, 32'h5000);
    wr(2'd0, mk(1'b1, 7'd2, 8'd7, 8'd1, 8'd1));
    pulse(1'b1, 1'b0);
    ptr = 32'h5000;
    pulse(1'b0, 1'b1);
    wr(2'd0, mk(1'b1, 7'd0, 8'd15, 8'd15, 8'd15));
    run_line(2, 8'd7, 8'd1, 8'd1, 0, "R10 old shape");
    chk(ptr == 32'h5012, "R10 pointer", ptr, 32'h5012);
    pulse(1'b0, 1'b1);
    run_line(0, 8'd15, 8'd15, 8'd15, 0, "R10 new shape");
  endtask

  task automatic t_disable();
    wr(2'd0, mk(1'b1, 7'd1, 8'd3, 8'd3, 8'd3));
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    wr(2'd0, 32'h0);
    run_line(1, 8'd3, 8'd3, 8'd3, 0, "R9 line completes");
    expect_idle(4, "R9 pending dropped");
    pulse(1'b0, 1'b1);
    expect_idle(4, "R9 strobe ignored");
  endtask

  task automatic t_bad_offset();
    wr(2'd0, mk(1'b1, 7'd0, 8'd3, 8'd3, 8'd3));
    wr(2'd2, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    pulse(1'b1, 1'b0);
    ptr = 32'h5000;
    pulse(1'b0, 1'b1);
    run_line(0, 8'd3, 8'd3, 8'd3, 0, "R2 other offsets ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    frame_start = 1'b0; line_start = 1'b0; req_ready = 1'b0; ptr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_count();
    t_underrun();
    t_frame_defer();
    t_same_cycle();
    t_snapshot();
    t_disable();
    t_bad_offset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule